// File: doc/BRIEF.md
# Retro Console CPU Bus Address Decoder

This block sits between an 8-bit CPU and the storage and peripherals of a retro console. It takes every 16-bit CPU address and picks the region it belongs to by looking at the top four address bits, which select one of sixteen 4 KB slots. Inside the chosen region the decoder forms the local address, steers the returned byte back to the CPU and raises the write enable that suits the target.

Work RAM is only 2 KB but fills an 8 KB window, so the decoder keeps only the low eleven address bits and every mirror reaches the same byte. Program ROM fills the upper half of the map. A store into that half never reaches storage; it becomes a pulse for the bank-switching logic.

Reads from space with no device return the last byte that travelled on the data bus. A register holds that byte and loads it at the end of every access. The video and I/O register blocks are not modelled here; the decoder only raises their chip selects and passes their shared read data to the CPU. Cartridge RAM is selected by a parameter. When that parameter is off, its window behaves as unmapped.

Top module: `retro_bus_decoder`

## Requirements
- R1: `cpu_addr[15:12]` selects the region, and each address belongs to exactly one region:
  - slots 0–1 go to work RAM;
  - slots 2–3 go to video registers;
  - slot 4 goes to I/O registers at offsets 0x000–0x01F and is unmapped at all other offsets;
  - slot 5 is unmapped;
  - slots 6–7 go to cartridge RAM;
  - slots 8–15 go to program ROM.
- R2: In work RAM, `ram_addr` equals `cpu_addr & 0x07FF`, and a write raises `ram_we` in the same cycle. Addresses 0x0805 and 0x1805 therefore return the byte stored at 0x0005.
- R3: A read from a mapped region puts that region's byte on `cpu_rdata` combinationally in the same cycle. The sources are:
  - `ram_rdata` for work RAM;
  - `rom_rdata` for ROM, with `rom_addr = cpu_addr[14:0]`;
  - `cram_rdata` for cartridge RAM, with `cram_addr = cpu_addr[12:0]`;
  - `dev_rdata` for the video and I/O blocks.
- R4: A write to 0x8000–0xFFFF raises `map_we` in that cycle and never raises `ram_we` or `cram_we`. A later read of the same address returns the unchanged ROM byte.
- R5: A write to 0x6000–0x7FFF raises `cram_we`, and a later read of the same address returns the written byte.
- R6: The open-bus byte is loaded at the clock edge that ends each access. It takes the write data on a write, and on a read it takes the byte returned. After reset it is 0x00. `cpu_rdata` shows it during unmapped reads and during cycles with no access.
- R7: `vid_cs` and `io_cs` are high only in a cycle with a read or write strobe to their region.
- R8: With `CART_RAM_EN = 0`, 0x6000–0x7FFF is unmapped. `cram_we` stays low, and reads there return the open-bus byte.
- R9: When `cpu_rd` and `cpu_wr` are both high, the cycle is a write: the target write enable rises and the open-bus byte takes `cpu_wdata`.
- R10: With neither strobe high, no write enable and no chip select is raised, and the open-bus byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one access per high cycle |
| cpu_wr | input | 1 | Write strobe, one access per high cycle |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_addr | output | 11 | Folded work RAM address |
| ram_we | output | 1 | Work RAM write enable |
| ram_rdata | input | 8 | Work RAM read data |
| rom_addr | output | 15 | Program ROM address |
| rom_rdata | input | 8 | Program ROM read data |
| cram_addr | output | 13 | Cartridge RAM address |
| cram_we | output | 1 | Cartridge RAM write enable |
| cram_rdata | input | 8 | Cartridge RAM read data |
| vid_cs | output | 1 | Video register block select |
| io_cs | output | 1 | I/O register block select |
| dev_rdata | input | 8 | Shared read data from the video and I/O blocks |
| map_we | output | 1 | Mapper register write strobe |

## Verification
Selects, write enables, folded addresses and read data from mapped regions are combinational, so each is due in the same cycle as its strobe. The open-bus byte is loaded at the clock edge that ends an access, so it can be seen no earlier than the next cycle, in an unmapped read or an idle cycle.

The bench drives every access on the falling edge. It pushes the expected values into a queue and compares them one nanosecond later, before the next rising edge. Checks of the open-bus byte are therefore always made in a later access than the one that loaded it.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [2:0] {
    RG_WRAM = 3'd0,
    RG_VID  = 3'd1,
    RG_IO   = 3'd2,
    RG_CRAM = 3'd3,
    RG_ROM  = 3'd4,
    RG_NONE = 3'd5
  } region_e;

  localparam int NUM_REGIONS = 6;
endpackage

// File: rtl/rbd_rst_sync.sv
module rbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rbd_slot_map.sv
module rbd_slot_map
  import rbd_pkg::*;
#(
  parameter int SLOT_BITS   = 4,
  parameter int HI_W        = 7,
  parameter bit CART_RAM_EN = 1'b1
) (
  input  logic [SLOT_BITS-1:0]   slot,
  input  logic [HI_W-1:0]        ofs_hi,
  output region_e                region,
  output logic [NUM_REGIONS-1:0] hit_oh
);
  localparam int NUM_SLOTS = 1 << SLOT_BITS;

  // Class of a whole slot, expressed in sixteenths of the address space.
  function automatic region_e slot_class(input int g);
    int sixteenth;
    sixteenth = (g * 16) / NUM_SLOTS;
    if (sixteenth < 2)       return RG_WRAM;
    else if (sixteenth < 4)  return RG_VID;
    else if (sixteenth == 4) return RG_IO;
    else if (sixteenth == 5) return RG_NONE;
    else if (sixteenth < 8)  return CART_RAM_EN ? RG_CRAM : RG_NONE;
    else                     return RG_ROM;
  endfunction

  region_e slot_kind [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_kind[g] = slot_class(g);
  end

  region_e kind;

  always_comb begin
    kind   = slot_kind[slot];
    region = kind;
    // The I/O block covers only the lowest span of its slot.
    if (kind == RG_IO && (|ofs_hi)) region = RG_NONE;
  end

  always_comb begin
    hit_oh         = '0;
    hit_oh[region] = 1'b1;
  end
endmodule

// File: rtl/rbd_bus_latch.sv
module rbd_bus_latch #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/retro_bus_decoder.sv
module retro_bus_decoder
  import rbd_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 8,
  parameter int                SLOT_BITS    = 4,
  parameter int                WRAM_AW      = 11,
  parameter int                CRAM_AW      = 13,
  parameter int                IO_SPAN_W    = 5,
  parameter bit                CART_RAM_EN  = 1'b1,
  parameter logic [DATA_W-1:0] OPEN_BUS_RST = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [WRAM_AW-1:0] ram_addr,
  output logic               ram_we,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [ADDR_W-2:0]  rom_addr,
  input  logic [DATA_W-1:0]  rom_rdata,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic               cram_we,
  input  logic [DATA_W-1:0]  cram_rdata,
  output logic               vid_cs,
  output logic               io_cs,
  input  logic [DATA_W-1:0]  dev_rdata,
  output logic               map_we
);
  localparam int OFS_W = ADDR_W - SLOT_BITS;
  localparam int HI_W  = OFS_W - IO_SPAN_W;

  logic                   rst_sync_n;
  region_e                region;
  logic [NUM_REGIONS-1:0] hit_oh;
  logic                   access;
  logic                   is_read;
  logic [DATA_W-1:0]      bus_q;
  logic [DATA_W-1:0]      bus_d;

  rbd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rbd_slot_map #(
    .SLOT_BITS   (SLOT_BITS),
    .HI_W        (HI_W),
    .CART_RAM_EN (CART_RAM_EN)
  ) u_map (
    .slot   (cpu_addr[ADDR_W-1 -: SLOT_BITS]),
    .ofs_hi (cpu_addr[OFS_W-1:IO_SPAN_W]),
    .region (region),
    .hit_oh (hit_oh)
  );

  // Local addresses: each region keeps only the low bits it decodes.
  assign ram_addr  = cpu_addr[WRAM_AW-1:0];
  assign rom_addr  = cpu_addr[ADDR_W-2:0];
  assign cram_addr = cpu_addr[CRAM_AW-1:0];

  assign access  = cpu_rd | cpu_wr;
  assign is_read = cpu_rd & ~cpu_wr;

  // Write steering. ROM space never reaches storage.
  assign ram_we  = cpu_wr & hit_oh[RG_WRAM];
  assign cram_we = cpu_wr & hit_oh[RG_CRAM];
  assign map_we  = cpu_wr & hit_oh[RG_ROM];
  assign vid_cs  = access & hit_oh[RG_VID];
  assign io_cs   = access & hit_oh[RG_IO];

  always_comb begin
    cpu_rdata = bus_q;
    if (is_read) begin
      unique case (region)
        RG_WRAM:       cpu_rdata = ram_rdata;
        RG_VID, RG_IO: cpu_rdata = dev_rdata;
        RG_CRAM:       cpu_rdata = cram_rdata;
        RG_ROM:        cpu_rdata = rom_rdata;
        default:       cpu_rdata = bus_q;
      endcase
    end
  end

  assign bus_d = cpu_wr ? cpu_wdata : cpu_rdata;

  rbd_bus_latch #(
    .W       (DATA_W),
    .RST_VAL (OPEN_BUS_RST)
  ) u_bus (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (access),
    .d     (bus_d),
    .q     (bus_q)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int WRAM_AW     = 11,
  parameter bit CART_RAM_EN = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      cpu_addr,
  input logic [DATA_W-1:0]      cpu_wdata,
  input logic                   cpu_rd,
  input logic                   cpu_wr,
  input logic [DATA_W-1:0]      cpu_rdata,
  input logic [WRAM_AW-1:0]     ram_addr,
  input logic                   ram_we,
  input logic                   cram_we,
  input logic                   map_we,
  input logic                   vid_cs,
  input logic                   io_cs,
  input logic [NUM_REGIONS-1:0] hit_oh
);
  // R1: exactly one region is decoded.
  p_one_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(hit_oh));

  // R2: the RAM write goes to the folded index, inside the RAM window.
  p_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr == cpu_addr[WRAM_AW-1:0]) && (cpu_addr[ADDR_W-1 -: 3] == 3'b000));

  // R4: a ROM-space write goes to the mapper, never to storage.
  p_rom_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[ADDR_W-1]) |-> (map_we && !ram_we && !cram_we));

  // R6: a write leaves its data on the open bus for an idle cycle.
  p_open_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> (cpu_rd || cpu_wr || cpu_rdata == $past(cpu_wdata)));

  // R7: the block selects need a strobe.
  p_cs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_cs || io_cs) |-> (cpu_rd || cpu_wr));

  // R8: with no cartridge RAM, its write enable never rises.
  p_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |-> (CART_RAM_EN && cpu_wr));

  // R10: an idle cycle raises nothing.
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> !(ram_we || cram_we || map_we || vid_cs || io_cs));
endmodule

bind retro_bus_decoder rbd_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .WRAM_AW     (WRAM_AW),
  .CART_RAM_EN (CART_RAM_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .ram_addr  (ram_addr),
  .ram_we    (ram_we),
  .cram_we   (cram_we),
  .map_we    (map_we),
  .vid_cs    (vid_cs),
  .io_cs     (io_cs),
  .hit_oh    (hit_oh)
);

// File: tb/retro_bus_decoder_bench.sv
`timescale 1ns/1ps
module retro_bus_decoder_bench;
  localparam int K_WRAM = 0, K_VID = 1, K_IO = 2, K_CRAM = 3, K_ROM = 4, K_NONE = 5;
  localparam int S_RDATA = 0, S_STROBE = 1, S_NOCR_RDATA = 2, S_NOCR_CWE = 3, S_RAMADDR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata, ram_rdata, rom_rdata, cram_rdata, dev_rdata;
  logic [10:0] ram_addr;
  logic [14:0] rom_addr;
  logic [12:0] cram_addr;
  logic        ram_we, cram_we, vid_cs, io_cs, map_we;
  logic [7:0]  n_rdata;
  logic [10:0] n_ram_addr;
  logic [14:0] n_rom_addr;
  logic [12:0] n_cram_addr;
  logic        n_ram_we, n_cram_we, n_vid_cs, n_io_cs, n_map_we;

  always #2 clk = ~clk;

  // External storage models.
  logic [7:0] bram [2048];
  logic [7:0] cmem [8192];

  function automatic logic [7:0] rom_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5C;
  endfunction

  assign ram_rdata  = bram[ram_addr];
  assign cram_rdata = cmem[cram_addr];
  assign rom_rdata  = rom_byte(rom_addr);
  assign dev_rdata  = cpu_addr[7:0] ^ 8'h96;

  always @(posedge clk) begin
    if (ram_we)  bram[ram_addr]  <= cpu_wdata;
    if (cram_we) cmem[cram_addr] <= cpu_wdata;
  end

  retro_bus_decoder u_retro_bus_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .cram_addr(cram_addr), .cram_we(cram_we), .cram_rdata(cram_rdata),
    .vid_cs(vid_cs), .io_cs(io_cs), .dev_rdata(dev_rdata), .map_we(map_we)
  );

  retro_bus_decoder #(.CART_RAM_EN(1'b0)) u_retro_bus_decoder_nocr (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(n_rdata),
    .ram_addr(n_ram_addr), .ram_we(n_ram_we), .ram_rdata(ram_rdata),
    .rom_addr(n_rom_addr), .rom_rdata(rom_rdata),
    .cram_addr(n_cram_addr), .cram_we(n_cram_we), .cram_rdata(cram_rdata),
    .vid_cs(n_vid_cs), .io_cs(n_io_cs), .dev_rdata(dev_rdata), .map_we(n_map_we)
  );

  // Reference state.
  logic [7:0] ref_wram [2048];
  logic [7:0] ref_cram [8192];
  logic [7:0] ob = 8'h00;

  typedef struct {
    int          sig;
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic int ref_region(input logic [15:0] a);
    if (a < 16'h2000)      return K_WRAM;
    else if (a < 16'h4000) return K_VID;
    else if (a < 16'h4020) return K_IO;
    else if (a < 16'h6000) return K_NONE;
    else if (a < 16'h8000) return K_CRAM;
    else                   return K_ROM;
  endfunction

  task automatic push(input int sig, input logic [15:0] v, input string tag);
    exp_t it;
    it.sig = sig; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Driver: one access per cycle, expectations pushed for the same cycle.
  task automatic op(input bit rd, input bit wr, input logic [15:0] a,
                    input logic [7:0] d, input string tag);
    int         k;
    logic [7:0] rv;
    logic [4:0] st;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    k = ref_region(a);
    case (k)
      K_WRAM:       rv = ref_wram[a[10:0]];
      K_VID, K_IO:  rv = a[7:0] ^ 8'h96;
      K_CRAM:       rv = ref_cram[a[12:0]];
      K_ROM:        rv = rom_byte(a[14:0]);
      default:      rv = ob;
    endcase
    st = {wr && k == K_WRAM, wr && k == K_CRAM, wr && k == K_ROM,
          (rd || wr) && k == K_VID, (rd || wr) && k == K_IO};
    push(S_STROBE, {11'd0, st}, tag);
    if (!wr) push(S_RDATA, {8'd0, rd ? rv : ob}, tag);
    if (k == K_WRAM && (rd || wr)) push(S_RAMADDR, {5'd0, a[10:0]}, tag);
    if (wr) begin
      if (k == K_WRAM) ref_wram[a[10:0]] = d;
      if (k == K_CRAM) ref_cram[a[12:0]] = d;
      ob = d;
    end else if (rd) begin
      ob = rv;
    end
  endtask

  // Monitor: compares every queued item one nanosecond after the falling edge.
  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      exp_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.sig)
        S_RDATA:      act = {8'd0, cpu_rdata};
        S_STROBE:     act = {11'd0, ram_we, cram_we, map_we, vid_cs, io_cs};
        S_NOCR_RDATA: act = {8'd0, n_rdata};
        S_NOCR_CWE:   act = {15'd0, n_cram_we};
        default:      act = {5'd0, ram_addr};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sig=%0d actual=%h expected=%h at %0t",
                 it.tag, it.sig, act, it.exp, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin bram[i] = 8'h00; ref_wram[i] = 8'h00; end
    for (int i = 0; i < 8192; i++) begin cmem[i] = 8'h00; ref_cram[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    op(0, 0, 16'h0000, 8'h00, "R6 reset value / R10 idle");
    op(1, 0, 16'h5000, 8'h00, "R6 reset open bus");
    op(0, 1, 16'h0005, 8'h3C, "R2 ram write");
    op(1, 0, 16'h1805, 8'h00, "R2 mirror 0x1805");
    op(1, 0, 16'h0805, 8'h00, "R2 mirror 0x0805");
    op(0, 1, 16'h9000, 8'h77, "R4 rom write to mapper");
    op(1, 0, 16'h9000, 8'h00, "R4 rom unchanged");
    op(1, 0, 16'h5123, 8'h00, "R6 open bus after read");
    op(0, 1, 16'h5000, 8'h11, "R1 unmapped write");
    op(1, 0, 16'h5000, 8'h00, "R6 open bus after write");
    op(1, 0, 16'h4010, 8'h00, "R7 io read");
    op(1, 0, 16'h4020, 8'h00, "R1 past io span");
    op(1, 0, 16'h2003, 8'h00, "R7 video read");
    op(0, 1, 16'h3FFF, 8'h42, "R7 video write");
    op(0, 1, 16'h6123, 8'h5A, "R5 cart ram write");
    push(S_NOCR_CWE, 16'd0, "R8 no cart write enable");
    op(0, 1, 16'h5000, 8'hE1, "R6 unmapped write");
    op(1, 0, 16'h6123, 8'h00, "R5 cart ram read");
    push(S_NOCR_RDATA, 16'h00E1, "R8 absent cart reads open bus");
    op(1, 0, 16'h7FFF, 8'h00, "R3 cart ram top");
    op(1, 1, 16'h0010, 8'h99, "R9 read and write");
    op(1, 0, 16'h5555, 8'h00, "R9 open bus took wdata");
    op(1, 0, 16'h0010, 8'h00, "R2 stored by combined strobe");
    op(0, 0, 16'h8000, 8'hFF, "R10 idle holds bus");
    op(0, 0, 16'h0000, 8'h00, "R10 idle again");
    op(1, 0, 16'hFFFF, 8'h00, "R3 rom top");
    op(1, 0, 16'hC001, 8'h00, "R3 rom mid");
    for (int i = 0; i < 16; i++) op(1, 0, {i[3:0], 12'h004}, 8'h00, "R1 slot sweep");
    op(0, 0, 16'h0000, 8'h00, "R10 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule